// File: doc/BRIEF.md
# Byte-Paced I2C Controller Engine

This block drives an I2C bus as the bus controller, one byte at a time under software control. Software loads a transmit byte and writes a command word. The command can open a transaction with START (or a repeated START when the bus is already owned) and send the loaded byte as the address. It can shift one data byte in the current direction, or close the transaction with STOP. After each step the engine parks the bus with SCL held low and raises an interrupt. Software then reads the status and the received byte before it issues the next command.

SCL and SDA are open-drain: an output enable of 1 pulls the line low and 0 releases it. An 8-bit prescale value sets the bit rate. Two error conditions end the transaction at once: a line held low by another device for longer than a programmable limit, and a lost arbitration. In both cases the engine releases both lines and returns to idle.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status reads 0x00, rxd reads 0x00, irq is low and both line enables are low (lines released).
- R2: One SCL period lasts 2*(P+2) clock cycles, where P is the prescale input saturated at 0xFD; prescale values 0xFE and 0xFF behave as 0xFD.
- R3: A command with kick (bit0), START (bit2) and mode enable (bit5) set, issued from idle, produces a START: SDA falls while SCL is high. The engine then sends the transmit byte MSB first. Status bit2 takes bit0 of that byte (1 = read).
- R4: From the parked state, kick+mode without START/STOP shifts one data byte MSB first, with SDA changing only while SCL is low. The byte is received when the address bit0 was 1 or when command bit7 is set; otherwise the transmit byte is sent.
- R5: On a received byte, the byte appears on rxd once the byte completes. On the 9th clock the engine pulls SDA low (ACK) when command bit3 was set, and releases it (NACK) when bit3 was clear.
- R6: At each byte end, status bit7 (byte done) is set and status bit0 shows SDA low on the 9th clock (ACK). Byte done with bit0 clear marks a missing acknowledge. Status bit6 is set when the address byte was acknowledged.
- R7: Kick+STOP (bit1)+mode from the parked state produces a STOP: SDA rises while SCL is high. Afterwards status bit5 (bus busy) is clear.
- R8: Kick+START+mode from the parked state produces a repeated START with no STOP in between, and the new address byte sets status bit2 again.
- R9: Status bit1 (pending) is set by byte done, STOP completion, timeout and arbitration loss. Any command write clears it, and also clears byte done. irq equals pending AND command bit6.
- R10: If SDA reads low during SCL high on a transmitted bit where the engine released SDA, status bit4 is set, both lines are released and the engine goes idle.
- R11: With a nonzero limit L, SCL or SDA held low by another device for L cycles during a transaction sets status bit3, releases both lines and returns the engine to idle. A limit of 0 disables the check.
- R12: A command with kick and state reset (bit4) set returns the engine to idle from any state, including mid-byte. It clears every status bit and releases both lines.
- R13: Commands are ignored while a byte, START or STOP is in progress, and also when mode enable is clear. STOP is ignored from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Command word write strobe |
| ctrl_data | input | 8 | Command word |
| txd_wr | input | 1 | Transmit byte write strobe |
| txd_data | input | 8 | Transmit byte (address or data) |
| prescale | input | 8 | SCL half-period setting |
| low_limit | input | TOUT_W | Low-line timeout limit in cycles, 0 disables |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| status | output | 8 | Status word |
| rxd | output | 8 | Last received byte |
| irq | output | 1 | Interrupt request |

## Verification
A phase counter or bit counter stuck in the wrong state shows up on the bus within a single byte. The bus model then sees too many or too few SCL rising edges, so the captured byte or ACK slot differs from the expected value. A wrong SCL half-period shows in the first measured SCL period after START. A misrouted error or status update shows up at the next poll of the status word, which happens one parked state later. Direction or ACK-drive errors show up as a wrong rxd value or a wrong 9th-bit level in the same byte.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RS0, ST_STA1, ST_STA2, ST_BLO, ST_BHI,
    ST_HOLD, ST_SP1, ST_SP2, ST_SP3
  } phase_e;

  // command word bit positions
  localparam int C_KICK  = 0;
  localparam int C_STOP  = 1;
  localparam int C_START = 2;
  localparam int C_ACK   = 3;
  localparam int C_SRST  = 4;
  localparam int C_MODE  = 5;
  localparam int C_IE    = 6;
  localparam int C_RX    = 7;

  localparam logic [7:0] PS_MAX = 8'hFD;

  // cycles per SCL half period
  function automatic logic [8:0] half_len(input logic [7:0] ps);
    logic [7:0] sat;
    sat = (ps > PS_MAX) ? PS_MAX : ps;
    return {1'b0, sat} + 9'd2;
  endfunction

endpackage

// File: rtl/i2cb_prescaler.sv
module i2cb_prescaler
  import i2cb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [7:0] prescale,
  output logic       tick
);
  logic [8:0] cnt;
  logic [8:0] half;

  assign half = half_len(prescale);
  assign tick = run && (cnt == half - 9'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 9'd1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/i2cb_low_timer.sv
module i2cb_low_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          scl_oe,
  input  logic          sda_oe,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  localparam logic [TW-1:0] CMAX = '1;
  logic [TW-1:0] cnt;
  logic          held;

  // low while this engine is not the one pulling it
  assign held    = active && ((!scl_in && !scl_oe) || (!sda_in && !sda_oe));
  assign expired = held && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!held)      cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end

  AST_TMO_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired); // R11
endmodule

// File: rtl/i2cb_byte_fsm.sv
module i2cb_byte_fsm
  import i2cb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       abort,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_data,
  input  logic       data_rx,
  input  logic       ack_en,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       run,
  output logic       idle,
  output logic       hold,
  output logic       ev_byte,
  output logic       ev_stop,
  output logic       ev_arb,
  output logic       ack_now,
  output logic       addr_phase,
  output logic [7:0] shreg
);
  phase_e     state;
  logic [3:0] bitcnt;
  logic       cur_rx, ack_q, bit_end, bit_low;

  assign idle       = (state == ST_IDLE);
  assign hold       = (state == ST_HOLD);
  assign run        = !idle && !hold;
  assign bit_end    = (state == ST_BHI) && tick;
  assign ev_arb     = bit_end && !cur_rx && (bitcnt < 4'd8) && shreg[7] && !sda_in;
  assign ev_byte    = bit_end && (bitcnt == 4'd8);
  assign ev_stop    = (state == ST_SP3) && tick;
  assign ack_now    = !sda_in;
  assign bit_low    = (bitcnt == 4'd8) ? (cur_rx && ack_q) : (!cur_rx && !shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0;
      cur_rx <= 1'b0; ack_q <= 1'b0; addr_phase <= 1'b0;
    end else if (abort) begin
      state <= ST_IDLE; bitcnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_start) begin
          shreg <= tx_byte; cur_rx <= 1'b0; addr_phase <= 1'b1; state <= ST_STA1;
        end
        ST_HOLD: begin
          if (cmd_start) begin
            shreg <= tx_byte; cur_rx <= 1'b0; addr_phase <= 1'b1; state <= ST_RS0;
          end else if (cmd_stop) begin
            state <= ST_SP1;
          end else if (cmd_data) begin
            shreg <= tx_byte; cur_rx <= data_rx; ack_q <= ack_en;
            addr_phase <= 1'b0; bitcnt <= '0; state <= ST_BLO;
          end
        end
        ST_RS0:  if (tick) state <= ST_STA1;
        ST_STA1: if (tick) state <= ST_STA2;
        ST_STA2: if (tick) begin state <= ST_BLO; bitcnt <= '0; end
        ST_BLO:  if (tick) state <= ST_BHI;
        ST_BHI:  if (tick) begin
          if (ev_arb)                  state <= ST_IDLE;
          else if (bitcnt == 4'd8)     state <= ST_HOLD;
          else begin
            shreg  <= {shreg[6:0], sda_in};
            bitcnt <= bitcnt + 4'd1;
            state  <= ST_BLO;
          end
        end
        ST_SP1:  if (tick) state <= ST_SP2;
        ST_SP2:  if (tick) state <= ST_SP3;
        ST_SP3:  if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe = 1'b0; sda_oe = 1'b0;
    case (state)
      ST_RS0, ST_HOLD: scl_oe = 1'b1;
      ST_STA2:         sda_oe = 1'b1;
      ST_BLO:          begin scl_oe = 1'b1; sda_oe = bit_low; end
      ST_BHI:          sda_oe = bit_low;
      ST_SP1:          begin scl_oe = 1'b1; sda_oe = 1'b1; end
      ST_SP2:          sda_oe = 1'b1;
      default:         ;
    endcase
  end

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BHI && $past(state == ST_BHI)) |-> $stable(sda_oe)); // R4
  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb |=> (!scl_oe && !sda_oe)); // R10
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_byte, ev_stop, ev_arb})); // R9
  AST_BYTE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && !abort) |=> (hold && scl_oe)); // R6
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int TOUT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_data,
  input  logic              txd_wr,
  input  logic [7:0]        txd_data,
  input  logic [7:0]        prescale,
  input  logic [TOUT_W-1:0] low_limit,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [7:0]        status,
  output logic [7:0]        rxd,
  output logic              irq
);
  logic [7:0] txd_q, shreg;
  logic ie_q, ack_q, pend_q, dir_q, tmo_q, arb_q, am_q, bds_q;
  logic tick, run, f_idle, f_hold, ev_byte, ev_stop, ev_arb, ack_now, addr_phase;
  logic tmo_hit, srst, accept, cmd_start, cmd_stop, cmd_data, abort;

  assign srst      = ctrl_wr && ctrl_data[C_KICK] && ctrl_data[C_SRST];
  assign accept    = ctrl_wr && ctrl_data[C_KICK] && !ctrl_data[C_SRST] && ctrl_data[C_MODE];
  assign cmd_start = accept && ctrl_data[C_START] && (f_idle || f_hold);
  assign cmd_stop  = accept && !ctrl_data[C_START] && ctrl_data[C_STOP] && f_hold;
  assign cmd_data  = accept && !ctrl_data[C_START] && !ctrl_data[C_STOP] && f_hold;
  assign abort     = srst || tmo_hit;

  i2cb_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .prescale(prescale), .tick(tick));

  i2cb_low_timer #(.TW(TOUT_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .active(!f_idle), .scl_in(scl_i), .sda_in(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .limit(low_limit), .expired(tmo_hit));

  i2cb_byte_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .abort(abort),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_data(cmd_data),
    .data_rx(dir_q || ctrl_data[C_RX]), .ack_en(ctrl_data[C_ACK]),
    .tx_byte(txd_q), .sda_in(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .run(run), .idle(f_idle), .hold(f_hold), .ev_byte(ev_byte),
    .ev_stop(ev_stop), .ev_arb(ev_arb), .ack_now(ack_now),
    .addr_phase(addr_phase), .shreg(shreg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= '0; rxd <= '0; ie_q <= 1'b0; ack_q <= 1'b0; pend_q <= 1'b0;
      dir_q <= 1'b0; tmo_q <= 1'b0; arb_q <= 1'b0; am_q <= 1'b0; bds_q <= 1'b0;
    end else begin
      if (txd_wr)  txd_q <= txd_data;
      if (ctrl_wr) ie_q  <= ctrl_data[C_IE];
      if (srst) begin
        rxd <= '0; ack_q <= 1'b0; pend_q <= 1'b0; dir_q <= 1'b0;
        tmo_q <= 1'b0; arb_q <= 1'b0; am_q <= 1'b0; bds_q <= 1'b0;
      end else begin
        if (ctrl_wr)   begin pend_q <= 1'b0; bds_q <= 1'b0; end
        if (cmd_start) begin dir_q <= txd_q[0]; am_q <= 1'b0; end
        if (ev_byte) begin
          bds_q <= 1'b1; pend_q <= 1'b1; ack_q <= ack_now; rxd <= shreg;
          if (addr_phase && ack_now) am_q <= 1'b1;
        end
        if (ev_stop)   pend_q <= 1'b1;
        if (ev_arb)    begin arb_q <= 1'b1; pend_q <= 1'b1; end
        if (tmo_hit)   begin tmo_q <= 1'b1; pend_q <= 1'b1; end
      end
    end
  end

  assign status = {bds_q, am_q, !f_idle, arb_q, tmo_q, dir_q, pend_q, ack_q};
  assign irq    = ie_q && pend_q;

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ev_byte && !ev_stop && !ev_arb && !tmo_hit) |=> !status[1]); // R9
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (status == 8'h00 && !scl_oe && !sda_oe)); // R12
endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  localparam logic [7:0] K = 8'h01, SP = 8'h02, ST = 8'h04, AK = 8'h08,
                         SR = 8'h10, MD = 8'h20, IE = 8'h40, RX = 8'h80;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ctrl_wr = 1'b0, txd_wr = 1'b0;
  logic [7:0] ctrl_data = '0, txd_data = '0, prescale = 8'd1;
  logic [15:0] low_limit = 16'd3000;
  logic scl_oe, sda_oe, irq;
  logic [7:0] status, rxd;
  logic slv_read = 1'b0, slv_ack = 1'b1, slv_low;
  logic [7:0] slv_byte = '0;
  logic [8:0] cap = '0;
  int idx = -1, starts = 0, stops = 0;
  int vectors = 0, fails = 0;
  logic scl_b, sda_b, ps_q = 1'b1, ds_q = 1'b1;

  assign scl_b = !scl_oe;
  assign sda_b = !(sda_oe || slv_low);

  always_comb begin
    slv_low = 1'b0;
    if (idx >= 0 && idx < 8) slv_low = slv_read && !slv_byte[3'(7 - idx)];
    else if (idx == 8)       slv_low = !slv_read && slv_ack;
  end

  // bus monitor / target model, sampled between clock edges
  always @(negedge clk) begin
    if (scl_b && ps_q && ds_q && !sda_b) begin starts++; idx = -1; end
    if (scl_b && ps_q && !ds_q && sda_b) stops++;
    if (scl_b && !ps_q) cap = {cap[7:0], sda_b};
    if (!scl_b && ps_q) idx = (idx == 8) ? 0 : idx + 1;
    ps_q = scl_b; ds_q = sda_b;
  end

  i2c_byte_master dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .txd_wr(txd_wr), .txd_data(txd_data), .prescale(prescale),
    .low_limit(low_limit), .scl_i(scl_b), .sda_i(sda_b),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .status(status), .rxd(rxd), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] w);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_data = w;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic settx(input logic [7:0] b);
    @(negedge clk); txd_wr = 1'b1; txd_data = b;
    @(negedge clk); txd_wr = 1'b0;
  endtask

  task automatic waitpend(input string req);
    int n = 0;
    while (!status[1] && n < 20000) begin @(negedge clk); n++; end
    chk(status[1], req, 0, 1);
  endtask

  task automatic open_tx(input logic [7:0] a, input string req);
    settx(a); ctl(MD | IE | ST | K); waitpend(req);
  endtask

  task automatic close_tx(input string req);
    ctl(MD | IE | SP | K); waitpend(req);
  endtask

  function automatic int exp_per(input int ps);
    return 2 * (((ps > 253) ? 253 : ps) + 2);
  endfunction

  task automatic measure(output int per);
    logic prev;
    int n;
    prev = scl_oe; n = 0;
    while (!(scl_oe && !prev) && n < 5000) begin prev = scl_oe; @(negedge clk); n++; end
    per = 0; prev = scl_oe;
    while (per < 5000) begin
      @(negedge clk); per++;
      if (scl_oe && !prev) break;
      prev = scl_oe;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int per, s0, p0;
    int ps_list[8] = '{0, 1, 2, 7, 64, 253, 254, 255};
    logic [7:0] wv[5] = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'hC3};
    logic [7:0] rv[4] = '{8'h3C, 8'hA5, 8'h00, 8'hFF};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'h00 && rxd == 8'h00, "R1", status, 0);
    chk(!irq && !scl_oe && !sda_oe, "R1", {irq, scl_oe, sda_oe}, 0);

    // R2 / R3 / R6 / R7 prescale sweep
    foreach (ps_list[i]) begin
      prescale = 8'(ps_list[i]);
      s0 = starts;
      settx(8'hA4); ctl(MD | ST | K);
      measure(per);
      chk(per == exp_per(ps_list[i]), "R2", per, exp_per(ps_list[i]));
      waitpend("R6");
      chk(starts == s0 + 1 && cap[8:1] == 8'hA4, "R3", cap[8:1], 8'hA4);
      chk(status[2] == 1'b0, "R3", status[2], 0);
      chk(status[0] && status[6] && status[7], "R6", status, 8'hE3);
      p0 = stops;
      close_tx("R7");
      chk(stops == p0 + 1 && !status[5], "R7", stops - p0, 1);
    end
    prescale = 8'd1;

    // R4 / R6 write data patterns, ACK and NACK
    open_tx(8'h20, "R3");
    foreach (wv[i]) begin
      slv_ack = (i % 2 == 0);
      settx(wv[i]); ctl(MD | IE | K); waitpend("R4");
      chk(cap[8:1] == wv[i], "R4", cap[8:1], wv[i]);
      chk(status[7] && status[0] == slv_ack, "R6", status[0], slv_ack);
    end
    slv_ack = 1'b1;
    close_tx("R7");

    // R5 read with ACK then final NACK
    open_tx(8'h21, "R3");
    chk(status[2] == 1'b1, "R3", status[2], 1);
    slv_read = 1'b1;
    foreach (rv[i]) begin
      slv_byte = rv[i];
      ctl(MD | IE | K | ((i == 3) ? 8'h00 : AK)); waitpend("R5");
      chk(rxd == rv[i], "R5", rxd, rv[i]);
      chk(cap[0] == (i == 3), "R5", cap[0], (i == 3));
      chk(status[0] == (i != 3), "R5", status[0], (i != 3));
    end
    slv_read = 1'b0;
    close_tx("R7");

    // R4 receive forced by command bit7 on a write-addressed transfer
    open_tx(8'h20, "R4");
    slv_read = 1'b1; slv_byte = 8'h96;
    ctl(MD | IE | K | RX); waitpend("R4");
    chk(rxd == 8'h96, "R4", rxd, 8'h96);
    slv_read = 1'b0;
    close_tx("R7");

    // R8 repeated START
    open_tx(8'hA0, "R8");
    settx(8'h10); ctl(MD | IE | K); waitpend("R8");
    s0 = starts; p0 = stops;
    open_tx(8'hA1, "R8");
    chk(starts == s0 + 1 && stops == p0, "R8", starts - s0, 1);
    chk(cap[8:1] == 8'hA1 && status[2] && status[5], "R8", cap[8:1], 8'hA1);
    slv_read = 1'b1; slv_byte = 8'h4E;
    ctl(MD | IE | K); waitpend("R8");
    chk(rxd == 8'h4E, "R8", rxd, 8'h4E);
    slv_read = 1'b0;
    close_tx("R7");

    // R9 pending and irq
    open_tx(8'h20, "R9");
    chk(irq == 1'b1, "R9", irq, 1);
    ctl(MD | IE);
    chk(!status[1] && !status[7] && !irq, "R9", status, 0);
    settx(8'h11); ctl(MD | K); waitpend("R9");
    chk(status[1] && !irq, "R9", irq, 0);
    close_tx("R9");

    // R13 ignored commands
    s0 = starts;
    ctl(ST | K); repeat (30) @(negedge clk);
    chk(!status[5] && starts == s0 && !scl_oe, "R13", status[5], 0);
    p0 = stops;
    ctl(MD | SP | K); repeat (30) @(negedge clk);
    chk(!status[5] && stops == p0 && !status[1], "R13", stops - p0, 0);
    open_tx(8'h20, "R13");
    s0 = starts;
    settx(8'h3C); ctl(MD | IE | K);
    repeat (5) @(negedge clk);
    ctl(MD | IE | ST | K); waitpend("R13");
    chk(cap[8:1] == 8'h3C && starts == s0, "R13", cap[8:1], 8'h3C);
    close_tx("R13");

    // R10 arbitration loss
    open_tx(8'h20, "R10");
    slv_read = 1'b1; slv_byte = 8'h00;
    settx(8'hFF); ctl(MD | IE | K); waitpend("R10");
    chk(status[4] && !status[5] && !status[7], "R10", status, 8'h12);
    chk(!scl_oe && !sda_oe, "R10", {scl_oe, sda_oe}, 0);
    slv_read = 1'b0;
    ctl(SR | K);
    chk(status == 8'h00, "R12", status, 0);

    // R11 low-line timeout
    low_limit = 16'd40;
    open_tx(8'h20, "R11");
    slv_read = 1'b1; slv_byte = 8'h00;
    repeat (20) @(negedge clk);
    chk(!status[3] && status[5], "R11", status[3], 0);
    repeat (40) @(negedge clk);
    chk(status[3] && status[1] && !status[5], "R11", status, 8'h0A);
    chk(!scl_oe && !sda_oe, "R11", {scl_oe, sda_oe}, 0);
    slv_read = 1'b0;
    ctl(SR | K);
    low_limit = 16'd3000;

    // R12 state reset mid-byte
    settx(8'h20); ctl(MD | IE | ST | K);
    repeat (10) @(negedge clk);
    ctl(SR | K);
    chk(status == 8'h00 && !scl_oe && !sda_oe, "R12", status, 0);
    open_tx(8'h20, "R12");
    chk(cap[8:1] == 8'h20 && status[0], "R12", cap[8:1], 8'h20);
    close_tx("R12");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule